// File: doc/BRIEF.md
# Single-Wire Keyboard Poll Host

This block is the host side of a single-wire, open-drain serial bus used to poll a keyboard-class device. On a start strobe it pulls the shared line low for a long wake-up period. It then transmits a one-byte "talk" command that carries a 4-bit device address and a 2-bit register number, and it follows the command with a stop bit. After that it listens for the device's 16-bit answer. Bits in both directions are carried in cells of roughly 100 µs, and the value of each bit is set by how long the cell stays low.

The line leaves the block only as a drive-low enable (`line_pull_o`). An external open-drain pad and a pull-up make the actual wire, and the wire level comes back on `line_in_i`. Every duration is counted in microsecond ticks, which a divider derives from the system clock. At the end of each transaction the block pulses `done_o` and presents a 16-bit result with a 2-bit status code.

Top module: `sw_poll_host`

## Requirements
- R1: `line_pull_o` is 0 during and after reset and whenever `busy_o` is 0.
- R2: A transaction opens with the line pulled low for 700 µs, directly followed by a logic-1 cell. The line is therefore low for 735 µs without a break.
- R3: A transmitted 1 is 35 µs low then 65 µs released. A transmitted 0 is 65 µs low then 35 µs released.
- R4: The command byte goes out MSB first as {address[3:0], 2'b11, register[1:0]}, so address 2 with register 0 gives 0x2C.
- R5: A 0 stop bit follows the command byte immediately.
- R6: If the line does not go low within 255 µs after the stop bit, the transaction ends with result 0x0000 and status 2'b01 (no data).
- R7: A reply made of a start bit of 1, 16 data bits MSB first and a stop bit of 0 ends the transaction with result equal to the data and status 2'b00 (ok).
- R8: Each received cell is read 55 µs after the line is seen low: low reads as 0 and high reads as 1. The receiver waits at most 75 µs for the low and at most 36 µs for the following high.
- R9: A start bit read as 0 ends the transaction with result 0xFFFE and status 2'b10.
- R10: A stop bit read as 1 ends the transaction with result 0xFFFD and status 2'b11.
- R11: `done_o` is high for exactly one clock per transaction. `result_o` and `status_o` change only in that cycle and hold their values until the next completion.
- R12: A start strobe that arrives while `busy_o` is 1 is ignored, and the command in flight is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a talk transaction (accepted when idle) |
| dev_addr_i | input | 4 | Device address placed in the command |
| reg_sel_i | input | 2 | Register number placed in the command |
| line_in_i | input | 1 | Level of the shared wire (asynchronous) |
| line_pull_o | output | 1 | 1 pulls the wire low, 0 releases it |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | 16 | Received data or error code |
| status_o | output | 2 | 00 ok, 01 no data, 10 bad start, 11 bad stop |

## Verification
The assertions check four things on every cycle: the line is released while idle, `done_o` is a single-cycle pulse, the result only moves together with `done_o`, and each error status carries its fixed result code. They also confirm that a strobe arriving mid-transaction neither restarts nor cuts short the work in flight. Only the bench scenarios can show the pulse widths on the wire, the command bit order, and the decoding of replies with different data patterns. The same applies to the no-reply timeout and the two framing errors, because each of these depends on a device model that answers with real cell timing.

// File: rtl/sw_poll_host.sv
module sw_poll_host #(
  parameter int CLK_HZ    = 4_000_000,
  parameter int ATTN_US   = 700,
  parameter int SHORT_US  = 35,
  parameter int LONG_US   = 65,
  parameter int RESP_US   = 255,
  parameter int FALL_US   = 75,
  parameter int SAMPLE_US = 55,
  parameter int RISE_US   = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  dev_addr_i,
  input  logic [1:0]  reg_sel_i,
  input  logic        line_in_i,
  output logic        line_pull_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] result_o,
  output logic [1:0]  status_o
);
  localparam int DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW  = $clog2(ATTN_US + 1);
  localparam logic [1:0] ST_OK = 2'b00, ST_NONE = 2'b01, ST_BSTART = 2'b10, ST_BSTOP = 2'b11;
  localparam logic [4:0] TX_LAST = 5'd10, RX_LAST = 5'd17;

  typedef enum logic [2:0] {S_IDLE, S_TXL, S_TXH, S_RESP, S_FALL, S_DLY, S_RISE} state_t;
  state_t state;

  logic [DW-1:0] div_cnt;
  logic [TW-1:0] tmr, low_len, high_len;
  logic [4:0]    idx;
  logic [7:0]    cmd;
  logic [15:0]   shreg;
  logic [1:0]    sync;
  logic          tick, line, tx_bit;

  assign tick        = (div_cnt == DW'(DIV - 1));
  assign line        = sync[1];
  assign line_pull_o = (state == S_TXL);
  assign busy_o      = (state != S_IDLE);
  assign tx_bit      = (idx == 5'd1) ? 1'b1 :
                       (idx >= 5'd2 && idx <= 5'd9) ? cmd[3'(5'd9 - idx)] : 1'b0;
  assign low_len     = (idx == 5'd0) ? TW'(ATTN_US) : tx_bit ? TW'(SHORT_US) : TW'(LONG_US);
  assign high_len    = (idx == 5'd0) ? '0 : tx_bit ? TW'(LONG_US) : TW'(SHORT_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sync    <= 2'b11;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      sync    <= {sync[0], line_in_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmr      <= '0;
      idx      <= '0;
      cmd      <= '0;
      shreg    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
      status_o <= ST_OK;
    end else begin
      done_o <= 1'b0;
      if (tick) tmr <= tmr + 1'b1;
      case (state)
        S_IDLE: if (start_i) begin
          cmd   <= {dev_addr_i, 2'b11, reg_sel_i};
          idx   <= '0;
          tmr   <= '0;
          state <= S_TXL;
        end
        S_TXL: if (tick && tmr == low_len - 1'b1) begin
          tmr <= '0;
          if (high_len == '0) idx <= idx + 1'b1;
          else state <= S_TXH;
        end
        S_TXH: if (tick && tmr == high_len - 1'b1) begin
          tmr <= '0;
          if (idx == TX_LAST) begin
            idx   <= '0;
            state <= S_RESP;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_TXL;
          end
        end
        S_RESP: if (!line) begin
          tmr   <= '0;
          state <= S_DLY;
        end else if (tick && tmr == TW'(RESP_US - 1)) begin
          state    <= S_IDLE;
          done_o   <= 1'b1;
          result_o <= 16'h0000;
          status_o <= ST_NONE;
        end
        S_FALL: if (!line || (tick && tmr == TW'(FALL_US - 1))) begin
          tmr   <= '0;
          state <= S_DLY;
        end
        S_DLY: if (tick && tmr == TW'(SAMPLE_US - 1)) begin
          tmr <= '0;
          if (idx == 5'd0 && !line) begin
            state    <= S_IDLE;
            done_o   <= 1'b1;
            result_o <= 16'hFFFE;
            status_o <= ST_BSTART;
          end else if (idx == RX_LAST) begin
            state    <= S_IDLE;
            done_o   <= 1'b1;
            result_o <= line ? 16'hFFFD : shreg;
            status_o <= line ? ST_BSTOP : ST_OK;
          end else begin
            if (idx != 5'd0) shreg <= {shreg[14:0], line};
            state <= S_RISE;
          end
        end
        S_RISE: if (line || (tick && tmr == TW'(RISE_US - 1))) begin
          tmr   <= '0;
          idx   <= idx + 1'b1;
          state <= S_FALL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_pull_o);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(status_o)));
  a_r12_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
  a_r6_none_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_NONE) |-> result_o == 16'h0000);
  a_r9_bstart_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_BSTART) |-> result_o == 16'hFFFE);
  a_r10_bstop_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_BSTOP) |-> result_o == 16'hFFFD);
endmodule

// File: tb/sw_poll_host_tb.sv
module sw_poll_host_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CPU = 2;
  localparam int  WATCHDOG = 190_000;

  logic clk = 0, rst_n = 0, start_i = 0, dev_pull = 0;
  logic [3:0] dev_addr_i = 4'h2;
  logic [1:0] reg_sel_i = 2'd0;
  logic line_w, line_pull_o, busy_o, done_o;
  logic [15:0] result_o;
  logic [1:0] status_o;
  int checks = 0, fails = 0, done_cnt = 0, cyc = 0;

  assign line_w = ~(line_pull_o | dev_pull);
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_o) done_cnt <= done_cnt + 1;
  end

  sw_poll_host #(.CLK_HZ(CPU * 1_000_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .reg_sel_i(reg_sel_i), .line_in_i(line_w), .line_pull_o(line_pull_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .status_o(status_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic near(input int n, input int us);
    return (n >= us * CPU - 4) && (n <= us * CPU + 4);
  endfunction

  task automatic meas(output int n);
    n = 0;
    while (!line_pull_o) @(negedge clk);
    while (line_pull_o) begin n++; @(negedge clk); end
  endtask

  task automatic send_cell(input logic b);
    dev_pull = 1;
    repeat ((b ? 35 : 65) * CPU) @(negedge clk);
    dev_pull = 0;
    repeat ((b ? 65 : 35) * CPU) @(negedge clk);
  endtask

  // kind: 0 ok reply, 1 no reply, 2 start bit 0, 3 stop bit 1
  task automatic do_txn(input logic [3:0] a, input logic [1:0] r, input int kind,
                        input logic [15:0] data, input logic poke);
    int n, base, bad;
    logic [7:0] got;
    logic [15:0] hold_r;
    logic [1:0] hold_s;
    base = done_cnt;
    @(negedge clk);
    dev_addr_i = a; reg_sel_i = r; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R12 busy after start", busy_o, 1);
    meas(n);
    chk("R2 attention low width ok", near(n, ATTN_TOTAL()), 1);
    if (poke) begin
      dev_addr_i = 4'hF; reg_sel_i = 2'd1; start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    bad = 0;
    for (int i = 7; i >= 0; i--) begin
      meas(n);
      got[i] = (n < 50 * CPU);
      if (!(near(n, 35) || near(n, 65))) bad++;
    end
    chk("R3 bit cell low widths", bad, 0);
    chk("R4 command byte", got, {a, 2'b11, r});
    meas(n);
    chk("R5 stop bit is 0", near(n, 65), 1);
    if (kind != 1) begin
      repeat (120 * CPU) @(negedge clk);
      send_cell(kind != 2);
      for (int i = 15; i >= 0; i--) send_cell(data[i]);
      send_cell(kind == 3);
    end
    for (int t = 0; t < 2000 && done_cnt == base; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R11 single done pulse", done_cnt - base, 1);
    chk("R1 idle releases line", line_pull_o, 0);
    case (kind)
      0: begin chk("R7 result data", result_o, data); chk("R7 status ok", status_o, 0); end
      1: begin chk("R6 result zero", result_o, 0); chk("R6 status none", status_o, 1); end
      2: begin chk("R9 result FFFE", result_o, 16'hFFFE); chk("R9 status", status_o, 2); end
      default: begin chk("R10 result FFFD", result_o, 16'hFFFD); chk("R10 status", status_o, 3); end
    endcase
    hold_r = result_o; hold_s = status_o;
    repeat (300) @(negedge clk);
    chk("R11 result held", {hold_s, hold_r}, {status_o, result_o});
  endtask

  function automatic int ATTN_TOTAL();
    return 735;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset pull", line_pull_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R11 reset done", done_o, 0);
  endtask

  task automatic t_default_ok();  do_txn(4'h2, 2'd0, 0, 16'hA55A, 0); endtask
  task automatic t_other_ok_r8(); do_txn(4'hB, 2'd3, 0, 16'h0001, 1); endtask
  task automatic t_pattern_r8();  do_txn(4'h7, 2'd2, 0, 16'hFF00, 0); endtask
  task automatic t_no_data();     do_txn(4'h5, 2'd1, 1, 16'h0000, 0); endtask
  task automatic t_bad_start();   do_txn(4'h2, 2'd0, 2, 16'h1234, 0); endtask
  task automatic t_bad_stop();    do_txn(4'h3, 2'd0, 3, 16'h8001, 0); endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_default_ok();
    t_other_ok_r8();
    t_pattern_r8();
    t_no_data();
    t_bad_start();
    t_bad_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule